// File: doc/BRIEF.md
# Special-Register Bank with Write Side-Effects

This block holds the special-purpose registers of a small RISC core. The core reaches them through move-to and move-from instructions. The core supplies a base and an immediate offset, and the block ORs them into a 16-bit register address. The upper bits of that address pick a group, starting at bit 11: group 0 is system control, group 9 is the interrupt controller and group 10 is the tick timer. The low bits pick a register inside the group. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high.

Several registers do more than store what is written. The status register always keeps its fixed-one bit set. A status write that changes any of the MMU-enable bits or the supervisor bit produces a one-cycle request to flush the translation buffers. Mask writes can only set mask bits, and status writes can only clear pending bits. The timer mode register has a pending bit that software can only clear. A write that changes the timer mode starts or stops the external counter. A read that hits no register returns the old destination value supplied by the core, so the destination is left unchanged.

Top module: `spr_bank`

## Requirements
- R1: The register address is `addr_base_i | addr_ofs_i`, with the group in bits 15:11. The mapped addresses are: 0x0000 version, 0x0001 unit-present, 0x0002 CPU config, 0x0003 data-MMU config, 0x0004 instruction-MMU config, 0x0010 next-PC, 0x0011 status, 0x0012 previous-PC, 0x0020 exception PC, 0x0030 exception address, 0x0040 exception status, 0x4800 interrupt mask, 0x4802 interrupt status, 0x5000 timer mode, 0x5001 timer count.
- R2: The four configuration registers (0x0001 to 0x0004) read back their parameter values, and writes to them are ignored.
- R3: The version, next-PC, previous-PC, exception PC, exception address, exception status and timer count registers read back the last value written.
- R4: After any write to the status register, bit 15 reads as 1 whatever value was written.
- R5: `tlb_flush_o` is high for exactly the one cycle after a write edge to the status register that changes bit 0 (supervisor), bit 5 (data-MMU enable) or bit 6 (instruction-MMU enable). It stays low for any other write.
- R6: A write to the interrupt mask ORs the data into the mask, so a mask bit is never cleared by a write.
- R7: A high bit on `pic_irq_i` at a clock edge sets the matching interrupt status bit, and the bit holds after the input falls. A write to interrupt status clears each bit whose data bit is 1. When an input sets a bit in the same cycle that a write clears it, the set wins.
- R8: Timer mode bit 28 is the pending bit, and `tmr_ip_set_i` sets it. On a timer mode write, a data value of 1 in bit 28 keeps the current pending bit. A data value of 0 clears the pending bit and drives `tmr_irq_clr_o` high for the one cycle after the edge.
- R9: Timer mode bits 31:30 hold the mode: 00 is disabled, and 01, 10 and 11 are counting modes. A timer mode write that changes the mode sets `tmr_run_o` to 0 for mode 00 and to 1 for any other mode. No other write changes `tmr_run_o`.
- R10: A read of an unmapped address returns `rd_old_i`.
- R11: After reset the status register reads 0x00008001 (supervisor on, fixed-one set, both MMUs off). Every other writable register reads 0, and all three outputs to the core are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for a move-to access |
| addr_base_i | input | 16 | Base part of the register address |
| addr_ofs_i | input | 16 | Immediate offset, ORed with the base |
| wdata_i | input | 32 | Write data |
| rd_old_i | input | 32 | Old destination value, returned on an unmapped read |
| pic_irq_i | input | 32 | Interrupt sources that set interrupt status bits |
| tmr_ip_set_i | input | 1 | Timer match event that sets the pending bit |
| rdata_o | output | 32 | Read data |
| tlb_flush_o | output | 1 | One-cycle request to flush all translation buffers |
| tmr_run_o | output | 1 | Enable for the tick counter |
| tmr_irq_clr_o | output | 1 | One-cycle request to drop the timer interrupt |

## Verification
The bench writes the status register twice in a row. One write toggles only a bit outside the MMU and supervisor set, which must not flush. The other toggles supervisor mode, which must flush. A design that compared the whole register would flush on the first write, and one that checked only the MMU bits would miss the second. The bench also sends a clearing write to interrupt status in the same cycle that a source fires, where a design that let the write win would lose an interrupt. Timer mode is written with the pending bit at 1 and at 0. A design that copied the written bit would let software raise a timer interrupt, or would never request the drop. The bench also checks that writes to the configuration registers are ignored and that unmapped reads return the old destination value and not zero.

// File: rtl/spr_bank_pkg.sv
package spr_bank_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_VER      = 16'h0000;
  localparam logic [ADDR_W-1:0] A_UNITS    = 16'h0001;
  localparam logic [ADDR_W-1:0] A_CPUCFG   = 16'h0002;
  localparam logic [ADDR_W-1:0] A_DMMUCFG  = 16'h0003;
  localparam logic [ADDR_W-1:0] A_IMMUCFG  = 16'h0004;
  localparam logic [ADDR_W-1:0] A_NPC      = 16'h0010;
  localparam logic [ADDR_W-1:0] A_STAT     = 16'h0011;
  localparam logic [ADDR_W-1:0] A_PPC      = 16'h0012;
  localparam logic [ADDR_W-1:0] A_EPC      = 16'h0020;
  localparam logic [ADDR_W-1:0] A_EADDR    = 16'h0030;
  localparam logic [ADDR_W-1:0] A_ESTAT    = 16'h0040;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 16'h4800;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 16'h4802;
  localparam logic [ADDR_W-1:0] A_TMR_MODE = 16'h5000;
  localparam logic [ADDR_W-1:0] A_TMR_CNT  = 16'h5001;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VER, SEL_UNITS, SEL_CPUCFG, SEL_DMMUCFG, SEL_IMMUCFG,
    SEL_NPC, SEL_STAT, SEL_PPC, SEL_EPC, SEL_EADDR, SEL_ESTAT,
    SEL_IRQ_MASK, SEL_IRQ_STAT, SEL_TMR_MODE, SEL_TMR_CNT
  } spr_sel_e;

  // plain storage registers, index order is the storage slot
  localparam int NPLAIN = 7;
  localparam spr_sel_e PLAIN_SEL [NPLAIN] =
    '{SEL_VER, SEL_NPC, SEL_PPC, SEL_EPC, SEL_EADDR, SEL_ESTAT, SEL_TMR_CNT};

  localparam int ST_SUPV_BIT  = 0;
  localparam int ST_DMMU_BIT  = 5;
  localparam int ST_IMMU_BIT  = 6;
  localparam int ST_ONE_BIT   = 15;
  localparam int TM_PEND_BIT  = 28;
  localparam int TM_MODE_LSB  = 30;
endpackage

// File: rtl/spr_addr_dec.sv
module spr_addr_dec
  import spr_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output spr_sel_e          sel_o
);
  logic [ADDR_W-1:0] addr;
  assign addr = base_i | ofs_i;

  always_comb begin
    case (addr)
      A_VER:      sel_o = SEL_VER;
      A_UNITS:    sel_o = SEL_UNITS;
      A_CPUCFG:   sel_o = SEL_CPUCFG;
      A_DMMUCFG:  sel_o = SEL_DMMUCFG;
      A_IMMUCFG:  sel_o = SEL_IMMUCFG;
      A_NPC:      sel_o = SEL_NPC;
      A_STAT:     sel_o = SEL_STAT;
      A_PPC:      sel_o = SEL_PPC;
      A_EPC:      sel_o = SEL_EPC;
      A_EADDR:    sel_o = SEL_EADDR;
      A_ESTAT:    sel_o = SEL_ESTAT;
      A_IRQ_MASK: sel_o = SEL_IRQ_MASK;
      A_IRQ_STAT: sel_o = SEL_IRQ_STAT;
      A_TMR_MODE: sel_o = SEL_TMR_MODE;
      A_TMR_CNT:  sel_o = SEL_TMR_CNT;
      default:    sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
  import spr_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  spr_sel_e                   sel_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NPLAIN-1:0][DW-1:0]  plain_o,
  output logic [DW-1:0]              stat_o,
  output logic                       flush_o
);
  localparam logic [DW-1:0] ONE_MASK  = DW'(1) << ST_ONE_BIT;
  localparam logic [DW-1:0] MODE_MASK = (DW'(1) << ST_SUPV_BIT) |
                                        (DW'(1) << ST_DMMU_BIT) |
                                        (DW'(1) << ST_IMMU_BIT);
  localparam logic [DW-1:0] STAT_RST  = ONE_MASK | (DW'(1) << ST_SUPV_BIT);

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && sel_i == PLAIN_SEL[i]) q <= wdata_i;
    end
    assign plain_o[i] = q;
  end

  logic wr_stat;
  assign wr_stat = we_i && (sel_i == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o  <= STAT_RST;
      flush_o <= 1'b0;
    end else begin
      flush_o <= wr_stat && |((stat_o ^ wdata_i) & MODE_MASK);
      if (wr_stat) stat_o <= wdata_i | ONE_MASK;
    end
  end
endmodule

// File: rtl/spr_pic_regs.sv
module spr_pic_regs
  import spr_bank_pkg::*;
#(
  parameter int NIRQ = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  spr_sel_e        sel_i,
  input  logic [NIRQ-1:0] wdata_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic [NIRQ-1:0] mask_o,
  output logic [NIRQ-1:0] status_o
);
  logic [NIRQ-1:0] clr;
  assign clr = (we_i && sel_i == SEL_IRQ_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      status_o <= '0;
    end else begin
      if (we_i && sel_i == SEL_IRQ_MASK) mask_o <= mask_o | wdata_i;
      // a source firing in the clearing cycle is not lost
      status_o <= (status_o & ~clr) | irq_i;
    end
  end
endmodule

// File: rtl/spr_tmr_regs.sv
module spr_tmr_regs
  import spr_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  spr_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ip_set_i,
  output logic [DW-1:0] mode_o,
  output logic          run_o,
  output logic          irq_clr_o
);
  logic          wr;
  logic [DW-1:0] mode_d;
  logic [1:0]    new_mode;

  assign wr       = we_i && (sel_i == SEL_TMR_MODE);
  assign new_mode = wdata_i[TM_MODE_LSB +: 2];

  always_comb begin
    mode_d = mode_o;
    if (wr) begin
      mode_d = wdata_i;
      mode_d[TM_PEND_BIT] = wdata_i[TM_PEND_BIT] & mode_o[TM_PEND_BIT];
    end
    if (ip_set_i) mode_d[TM_PEND_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= '0;
      run_o     <= 1'b0;
      irq_clr_o <= 1'b0;
    end else begin
      mode_o    <= mode_d;
      irq_clr_o <= wr && !wdata_i[TM_PEND_BIT];
      if (wr && new_mode != mode_o[TM_MODE_LSB +: 2]) run_o <= (new_mode != 2'b00);
    end
  end
endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_bank_pkg::*;
#(
  parameter int          DW          = 32,
  parameter int          NIRQ        = 32,
  parameter logic [31:0] UNITS_VAL   = 32'h0000_0701,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [15:0]     addr_base_i,
  input  logic [15:0]     addr_ofs_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   rd_old_i,
  input  logic [NIRQ-1:0] pic_irq_i,
  input  logic            tmr_ip_set_i,
  output logic [DW-1:0]   rdata_o,
  output logic            tlb_flush_o,
  output logic            tmr_run_o,
  output logic            tmr_irq_clr_o
);
  spr_sel_e                  sel;
  logic [NPLAIN-1:0][DW-1:0] plain;
  logic [DW-1:0]             stat_q;
  logic [NIRQ-1:0]           pic_mask;
  logic [NIRQ-1:0]           pic_stat;
  logic [DW-1:0]             tmr_mode;

  spr_addr_dec u_dec (
    .base_i (addr_base_i),
    .ofs_i  (addr_ofs_i),
    .sel_o  (sel)
  );

  spr_sys_regs #(.DW(DW)) u_sys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .plain_o (plain),
    .stat_o  (stat_q),
    .flush_o (tlb_flush_o)
  );

  spr_pic_regs #(.NIRQ(NIRQ)) u_pic (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i[NIRQ-1:0]),
    .irq_i    (pic_irq_i),
    .mask_o   (pic_mask),
    .status_o (pic_stat)
  );

  spr_tmr_regs #(.DW(DW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .ip_set_i  (tmr_ip_set_i),
    .mode_o    (tmr_mode),
    .run_o     (tmr_run_o),
    .irq_clr_o (tmr_irq_clr_o)
  );

  logic [DW-1:0] plain_rd;
  logic          plain_hit;
  always_comb begin
    plain_rd  = '0;
    plain_hit = 1'b0;
    for (int i = 0; i < NPLAIN; i++) begin
      if (sel == PLAIN_SEL[i]) begin
        plain_rd  = plain[i];
        plain_hit = 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_UNITS:    rdata_o = DW'(UNITS_VAL);
      SEL_CPUCFG:   rdata_o = DW'(CPUCFG_VAL);
      SEL_DMMUCFG:  rdata_o = DW'(DMMUCFG_VAL);
      SEL_IMMUCFG:  rdata_o = DW'(IMMUCFG_VAL);
      SEL_STAT:     rdata_o = stat_q;
      SEL_IRQ_MASK: rdata_o = DW'(pic_mask);
      SEL_IRQ_STAT: rdata_o = DW'(pic_stat);
      SEL_TMR_MODE: rdata_o = tmr_mode;
      default:      rdata_o = plain_hit ? plain_rd : rd_old_i;
    endcase
  end
endmodule

// File: rtl/spr_bank_chk.sv
module spr_bank_chk
  import spr_bank_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NIRQ = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [15:0]     addr_base_i,
  input logic [15:0]     addr_ofs_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   stat_i,
  input logic [NIRQ-1:0] mask_i,
  input logic            tlb_flush_o,
  input logic            tmr_run_o,
  input logic            tmr_irq_clr_o
);
  logic [15:0] addr;
  assign addr = addr_base_i | addr_ofs_i;

  assert_one_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[ST_ONE_BIT]);

  assert_mask_grows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((mask_i & $past(mask_i)) == $past(mask_i)));

  assert_flush_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> $past(we_i && addr == A_STAT));

  assert_irq_clr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_irq_clr_o |-> $past(we_i && addr == A_TMR_MODE && !wdata_i[TM_PEND_BIT]));

  assert_run_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tmr_run_o) |-> $past(we_i && addr == A_TMR_MODE));
endmodule

bind spr_bank spr_bank_chk #(.DW(DW), .NIRQ(NIRQ)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (we_i),
  .addr_base_i   (addr_base_i),
  .addr_ofs_i    (addr_ofs_i),
  .wdata_i       (wdata_i),
  .stat_i        (stat_q),
  .mask_i        (pic_mask),
  .tlb_flush_o   (tlb_flush_o),
  .tmr_run_o     (tmr_run_o),
  .tmr_irq_clr_o (tmr_irq_clr_o)
);

// File: tb/spr_bank_bench.sv
module spr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [15:0] base = '0, ofs = '0;
  logic [31:0] wdata = '0, rd_old = '0;
  logic [31:0] irq = '0;
  logic        ip_set = 1'b0;
  logic [31:0] rdata;
  logic        flush, run, irq_clr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spr_bank u_spr_bank (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .we_i          (we),
    .addr_base_i   (base),
    .addr_ofs_i    (ofs),
    .wdata_i       (wdata),
    .rd_old_i      (rd_old),
    .pic_irq_i     (irq),
    .tmr_ip_set_i  (ip_set),
    .rdata_o       (rdata),
    .tlb_flush_o   (flush),
    .tmr_run_o     (run),
    .tmr_irq_clr_o (irq_clr)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] b;
    logic [15:0] o;
    logic [31:0] d;
    logic [31:0] old;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0010, 16'h0001, 32'h0,         32'h0,         32'h0000_8001}, // R11 R1
    '{1'b1, 16'h0011, 16'h0000, 32'h0,         32'h0,         32'h0000_8000}, // R4
    '{1'b1, 16'h0000, 16'h0000, 32'h1234_5678, 32'h0,         32'h1234_5678}, // R3
    '{1'b1, 16'h0000, 16'h0001, 32'hFFFF_FFFF, 32'h0,         32'h0000_0701}, // R2
    '{1'b1, 16'h0002, 16'h0000, 32'h0,         32'h0,         32'h0000_0020}, // R2
    '{1'b0, 16'h0003, 16'h0000, 32'h0,         32'h0,         32'h0000_0018}, // R2
    '{1'b1, 16'h0004, 16'h0000, 32'h5555_5555, 32'h0,         32'h0000_0018}, // R2
    '{1'b1, 16'h0010, 16'h0000, 32'h0000_1000, 32'h0,         32'h0000_1000}, // R3
    '{1'b1, 16'h0012, 16'h0000, 32'h0000_0FFC, 32'h0,         32'h0000_0FFC}, // R3
    '{1'b1, 16'h0020, 16'h0000, 32'h0000_2000, 32'h0,         32'h0000_2000}, // R3
    '{1'b1, 16'h0030, 16'h0000, 32'hDEAD_BEEF, 32'h0,         32'hDEAD_BEEF}, // R3
    '{1'b1, 16'h0000, 16'h0040, 32'hA5A5_A5A5, 32'h0,         32'hA5A5_A5A5}, // R3 R1
    '{1'b1, 16'h4800, 16'h0000, 32'h0000_00F0, 32'h0,         32'h0000_00F0}, // R6
    '{1'b1, 16'h4800, 16'h0000, 32'h0000_000F, 32'h0,         32'h0000_00FF}, // R6
    '{1'b1, 16'h4000, 16'h0800, 32'h0,         32'h0,         32'h0000_00FF}, // R6 R1
    '{1'b0, 16'h0005, 16'h0000, 32'h0,         32'hCAFE_F00D, 32'hCAFE_F00D}, // R10
    '{1'b1, 16'h0100, 16'h0000, 32'h0000_0055, 32'h1111_2222, 32'h1111_2222}, // R10
    '{1'b0, 16'h4801, 16'h0000, 32'h0,         32'h3333_4444, 32'h3333_4444}, // R10
    '{1'b1, 16'h5000, 16'h0001, 32'h00AB_CDEF, 32'h0,         32'h00AB_CDEF}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; base = a; ofs = '0; wdata = d;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] old, output logic [31:0] v);
    base = a; ofs = '0; rd_old = old;
    #1;
    v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    #23 rst_ni = 1'b1;
    #1;
    check("R11 flush", {31'b0, flush}, 32'h0);
    check("R11 run", {31'b0, run}, 32'h0);
    check("R11 irq_clr", {31'b0, irq_clr}, 32'h0);
    rd(16'h4802, 32'h0, v); check("R11 irq status", v, 32'h0);
    rd(16'h5000, 32'h0, v); check("R11 timer mode", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].wr; base = VECS[i].b; ofs = VECS[i].o; wdata = VECS[i].d;
      @(negedge clk);
      we = 1'b0; rd_old = VECS[i].old;
      #1;
      check($sformatf("vector %0d", i), rdata, VECS[i].exp);
    end

    // R5: status register flush behaviour
    wr(16'h0011, 32'h0000_0020);
    check("R5 flush on DMMU set", {31'b0, flush}, 32'h1);
    rd(16'h0011, 32'h0, v); check("R4 status", v, 32'h0000_8020);
    @(negedge clk); #1;
    check("R5 flush one cycle", {31'b0, flush}, 32'h0);
    wr(16'h0011, 32'h0000_0024);
    check("R5 no flush on other bit", {31'b0, flush}, 32'h0);
    wr(16'h0011, 32'h0000_0025);
    check("R5 flush on supervisor", {31'b0, flush}, 32'h1);
    wr(16'h0011, 32'h0000_8065);
    check("R5 flush on IMMU", {31'b0, flush}, 32'h1);

    // R7: interrupt status
    @(negedge clk); irq = 32'h0000_00FF;
    @(negedge clk); irq = '0;
    rd(16'h4802, 32'h0, v); check("R7 sticky set", v, 32'h0000_00FF);
    wr(16'h4802, 32'h0000_000F);
    rd(16'h4802, 32'h0, v); check("R7 write clears", v, 32'h0000_00F0);
    @(negedge clk);
    we = 1'b1; base = 16'h4802; wdata = 32'h0000_0030; irq = 32'h0000_0010;
    @(negedge clk);
    we = 1'b0; irq = '0;
    rd(16'h4802, 32'h0, v); check("R7 set wins", v, 32'h0000_00D0);

    // R8 / R9: timer mode
    wr(16'h5000, 32'h4000_0000);
    check("R9 run on restart mode", {31'b0, run}, 32'h1);
    check("R8 clr on pend=0 write", {31'b0, irq_clr}, 32'h1);
    @(negedge clk); ip_set = 1'b1;
    @(negedge clk); ip_set = 1'b0;
    rd(16'h5000, 32'h0, v); check("R8 pend set", v, 32'h5000_0000);
    wr(16'h5000, 32'hD000_0000);
    check("R8 no clr on pend=1", {31'b0, irq_clr}, 32'h0);
    rd(16'h5000, 32'h0, v); check("R8 pend kept", v, 32'hD000_0000);
    wr(16'h5000, 32'hC000_0000);
    check("R8 clr pulse", {31'b0, irq_clr}, 32'h1);
    rd(16'h5000, 32'h0, v); check("R8 pend cleared", v, 32'hC000_0000);
    wr(16'h5000, 32'h0000_0000);
    check("R9 stop on disabled", {31'b0, run}, 32'h0);
    wr(16'h5001, 32'h0000_0001);
    check("R9 count write keeps run", {31'b0, run}, 32'h0);
    wr(16'h5000, 32'h8000_0000);
    check("R9 start on one-shot", {31'b0, run}, 32'h1);

    // R11: reset in mid-run
    @(negedge clk); rst_ni = 1'b0; #1;
    rd(16'h0011, 32'h0, v); check("R11 status after reset", v, 32'h0000_8001);
    rd(16'h4800, 32'h0, v); check("R11 mask after reset", v, 32'h0);
    rd(16'h0010, 32'h0, v); check("R11 plain after reset", v, 32'h0);
    check("R11 run after reset", {31'b0, run}, 32'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule